// File: doc/BRIEF.md
# Tick Counter with Programmable Alarm Interval

This peripheral keeps a free-running 32-bit tick count in its own counting clock domain and raises a periodic alarm after a programmed number of ticks. Its configuration lives in a small register file on the bus clock. The counting domain gets its ticks from one of four tick-enable sources. An optional divide-by-32 stage and an optional divide-by-512 stage can slow the tick rate. The current count is exported on a port.

The interval timer has its own counter. This counter advances on each divided tick and restarts after it matches the programmed interval. Each match sets a sticky flag on the bus side, which can drive an interrupt line. A new interval value crosses into the counting domain through a toggle handshake. While that transfer is in flight, a busy status bit stays set and further interval writes are dropped.

Software must stop the counter before it changes the source or the prescaler settings. The register file enforces this: it ignores those fields while the run bit is set.

Top module: `rtc_api_timer`

## Requirements
- R1: After reset the control word (offset 0x4), the status word (offset 0x8) and the interval register (offset 0x10) read 0, `cntValue` is 0, `apiIrq` is 0 and the counter does not advance.
- R2: With the run bit (control bit 31) set, `cntValue` advances once per divided tick. Control bit 10 divides the selected source by 32 and bit 11 divides it by 512. With both bits set the source is divided by 16384, and with neither set it is not divided.
- R3: Control bits 13:12 select which `srcTick` line is counted. A write that selects index 1 leaves the current selection unchanged.
- R4: Writes to bits 13:12, 11 and 10 take effect only when the stored run bit is 0. The run bit, the interval-enable bit 15 and the interrupt-enable bit 14 are written on every control write. All other control bits read 0.
- R5: While the run bit is 0, `cntValue` and the prescaler state hold their values.
- R6: With bit 15 set and the counter running, once a value N is loaded, the interval flag (status bit 13) is set every N divided ticks. N = 0 never sets the flag.
- R7: The flag is sticky. Writing 1 to status bit 13 clears it, and writing 0 there has no effect. If a match arrives in the same cycle as a clear, the flag stays set.
- R8: `apiIrq` is high exactly when the flag and control bit 14 are both 1.
- R9: A write to offset 0x10 makes status bit 17 read 1 from the next cycle until the value has reached the counting domain, after which it reads 0. Reads of 0x10 return the last accepted value.
- R10: A write to offset 0x10 while status bit 17 is 1 is ignored.
- R11: Reads of any offset other than 0x4, 0x8 and 0x10 return 0, and `rdData` is 0 when `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register-file clock |
| busRstN | input | 1 | Asynchronous active-low reset, bus domain |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 5 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` while `rdEn` is high |
| apiIrq | output | 1 | Interval interrupt request |
| cntClk | input | 1 | Counting-domain clock |
| cntRstN | input | 1 | Asynchronous active-low reset, counting domain |
| srcTick | input | 4 | Per-source tick enables, counting domain |
| cntValue | output | 32 | Free-running tick count, counting domain |

## Verification
Two pairs of events can land in the same cycle.

The first pair is an interval load arriving in the counting domain and a divided tick. Source 0 is tied high, so every load that reaches the counting domain meets a tick. The bench judges the outcome by measuring the distance between two successive flag rises in `cntValue`. That distance must equal the loaded value exactly, both for directed values and for random ones.

The second pair is a match reaching the flag and a software clear of the flag. The checker requires the flag to be set in the cycle after every synchronized match, whatever the bus is writing. The bench repeats a clear until the status read shows the flag low, so a clear that is lost to a match does not cost a check.

// File: rtl/rtc_api_pkg.sv
package rtc_api_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 2;
  localparam int SRC_N = 1 << SEL_W;

  localparam int OFS_CTRL = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_API  = 'h10;

  localparam int BIT_RUN    = 31;
  localparam int BIT_APIEN  = 15;
  localparam int BIT_IRQEN  = 14;
  localparam int BIT_SEL_LO = 12;
  localparam int BIT_DIV512 = 11;
  localparam int BIT_DIV32  = 10;
  localparam int BIT_BUSY   = 17;
  localparam int BIT_FLAG   = 13;

  localparam logic [SEL_W-1:0] SRC_RESERVED = SEL_W'(1);

  // bus-side settings and the interval-load toggle seen by the counting domain
  typedef struct packed {
    logic             run;
    logic             apiOn;
    logic [SEL_W-1:0] srcSel;
    logic             div512;
    logic             div32;
    logic             apiReq;
  } cfg_t;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_api_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              ackTog,
  input  logic              hitTog,
  output logic [REG_W-1:0]  rdData,
  output logic              apiIrq,
  output cfg_t              cfg,
  output logic [REG_W-1:0]  apiHold,
  output logic              busyQ,
  output logic              flagQ,
  output logic              hitEvt
);
  cfg_t             cfgQ;
  logic             irqEnQ;
  logic             flagR;
  logic [REG_W-1:0] holdQ;
  logic             hitPrev;
  logic [1:0]       backSync;
  logic             selCtrl, selStat, selApi;
  logic [SEL_W-1:0] wrSel;

  rtc_sync #(.WIDTH(2), .STAGES(2)) uBackSync (
    .clk (busClk),
    .rstN(busRstN),
    .d   ({ackTog, hitTog}),
    .q   (backSync)
  );

  assign busyQ   = cfgQ.apiReq != backSync[1];
  assign hitEvt  = backSync[0] != hitPrev;
  assign selCtrl = wrEn && (addr == ADDR_W'(OFS_CTRL));
  assign selStat = wrEn && (addr == ADDR_W'(OFS_STAT));
  assign selApi  = wrEn && (addr == ADDR_W'(OFS_API));
  assign wrSel   = wrData[BIT_SEL_LO +: SEL_W];

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      cfgQ    <= '0;
      irqEnQ  <= 1'b0;
      flagR   <= 1'b0;
      holdQ   <= '0;
      hitPrev <= 1'b0;
    end else begin
      hitPrev <= backSync[0];
      if (selCtrl) begin
        cfgQ.run   <= wrData[BIT_RUN];
        cfgQ.apiOn <= wrData[BIT_APIEN];
        irqEnQ     <= wrData[BIT_IRQEN];
        if (!cfgQ.run) begin
          if (wrSel != SRC_RESERVED) cfgQ.srcSel <= wrSel;
          cfgQ.div512 <= wrData[BIT_DIV512];
          cfgQ.div32  <= wrData[BIT_DIV32];
        end
      end
      if (selApi && !busyQ) begin
        holdQ       <= wrData;
        cfgQ.apiReq <= ~cfgQ.apiReq;
      end
      if (hitEvt)                          flagR <= 1'b1;
      else if (selStat && wrData[BIT_FLAG]) flagR <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == ADDR_W'(OFS_CTRL)) begin
        rdData[BIT_RUN]                 = cfgQ.run;
        rdData[BIT_APIEN]               = cfgQ.apiOn;
        rdData[BIT_IRQEN]               = irqEnQ;
        rdData[BIT_SEL_LO +: SEL_W]     = cfgQ.srcSel;
        rdData[BIT_DIV512]              = cfgQ.div512;
        rdData[BIT_DIV32]               = cfgQ.div32;
      end else if (addr == ADDR_W'(OFS_STAT)) begin
        rdData[BIT_BUSY] = busyQ;
        rdData[BIT_FLAG] = flagR;
      end else if (addr == ADDR_W'(OFS_API)) begin
        rdData = holdQ;
      end
    end
  end

  assign apiIrq  = flagR && irqEnQ;
  assign flagQ   = flagR;
  assign cfg     = cfgQ;
  assign apiHold = holdQ;
endmodule

// File: rtl/rtc_count_path.sv
module rtc_count_path
  import rtc_api_pkg::*;
#(
  parameter int PRE_A_LOG2 = 5,
  parameter int PRE_B_LOG2 = 9
) (
  input  logic             cntClk,
  input  logic             cntRstN,
  input  logic [SRC_N-1:0] srcTick,
  input  cfg_t             cfg,
  input  logic [REG_W-1:0] apiHold,
  output logic [REG_W-1:0] cntValue,
  output logic             ackTog,
  output logic             hitTog,
  output logic             runLive
);
  cfg_t                  cfgS;
  logic [PRE_A_LOG2-1:0] preA;
  logic [PRE_B_LOG2-1:0] preB;
  logic [REG_W-1:0]      cntQ, apiVal, apiCnt;
  logic                  reqSeen, hitQ;
  logic                  tick, stageA, stageB, loadNow;

  rtc_sync #(.WIDTH($bits(cfg_t)), .STAGES(2)) uCfgSync (
    .clk (cntClk),
    .rstN(cntRstN),
    .d   (cfg),
    .q   (cfgS)
  );

  assign tick    = cfgS.run && srcTick[cfgS.srcSel];
  assign stageA  = cfgS.div32  ? (tick && (&preA))   : tick;
  assign stageB  = cfgS.div512 ? (stageA && (&preB)) : stageA;
  assign loadNow = cfgS.apiReq != reqSeen;

  always_ff @(posedge cntClk or negedge cntRstN) begin
    if (!cntRstN) begin
      preA    <= '0;
      preB    <= '0;
      cntQ    <= '0;
      apiVal  <= '0;
      apiCnt  <= '0;
      reqSeen <= 1'b0;
      hitQ    <= 1'b0;
    end else begin
      if (tick && cfgS.div32)    preA <= preA + 1'b1;
      if (stageA && cfgS.div512) preB <= preB + 1'b1;
      if (stageB)                cntQ <= cntQ + 1'b1;
      if (loadNow) begin
        apiVal  <= apiHold;
        apiCnt  <= '0;
        reqSeen <= cfgS.apiReq;
      end else if (!cfgS.apiOn) begin
        apiCnt <= '0;
      end else if (stageB && (apiVal != '0)) begin
        if ((apiCnt + REG_W'(1)) == apiVal) begin
          apiCnt <= '0;
          hitQ   <= ~hitQ;
        end else begin
          apiCnt <= apiCnt + REG_W'(1);
        end
      end
    end
  end

  assign cntValue = cntQ;
  assign ackTog   = reqSeen;
  assign hitTog   = hitQ;
  assign runLive  = cfgS.run;
endmodule

// File: rtl/rtc_api_timer.sv
module rtc_api_timer
  import rtc_api_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int PRE_A_LOG2 = 5,
  parameter int PRE_B_LOG2 = 9
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              apiIrq,
  input  logic              cntClk,
  input  logic              cntRstN,
  input  logic [SRC_N-1:0]  srcTick,
  output logic [REG_W-1:0]  cntValue
);
  cfg_t             cfg;
  logic [REG_W-1:0] apiHold;
  logic             ackTog, hitTog, busyQ, flagQ, hitEvt, runLive;

  rtc_bus_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busClk (busClk),
    .busRstN(busRstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .ackTog (ackTog),
    .hitTog (hitTog),
    .rdData (rdData),
    .apiIrq (apiIrq),
    .cfg    (cfg),
    .apiHold(apiHold),
    .busyQ  (busyQ),
    .flagQ  (flagQ),
    .hitEvt (hitEvt)
  );

  rtc_count_path #(.PRE_A_LOG2(PRE_A_LOG2), .PRE_B_LOG2(PRE_B_LOG2)) uPath (
    .cntClk  (cntClk),
    .cntRstN (cntRstN),
    .srcTick (srcTick),
    .cfg     (cfg),
    .apiHold (apiHold),
    .cntValue(cntValue),
    .ackTog  (ackTog),
    .hitTog  (hitTog),
    .runLive (runLive)
  );
endmodule

// File: rtl/rtc_api_checker.sv
module rtc_api_checker
  import rtc_api_pkg::*;
(
  input logic             busClk,
  input logic             busRstN,
  input logic             cntClk,
  input logic             cntRstN,
  input logic             wrApiStb,
  input logic             wrClrStb,
  input logic             busyQ,
  input logic             flagQ,
  input logic             hitEvt,
  input cfg_t             cfg,
  input logic [REG_W-1:0] apiHold,
  input logic             runLive,
  input logic [REG_W-1:0] cntValue
);
  AST_BUSY_ON_LOAD: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrApiStb && !busyQ) |=> busyQ);                                  // R9
  AST_HOLD_LOCKED: assert property (@(posedge busClk) disable iff (!busRstN)
    busyQ |=> $stable(apiHold));                                      // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge busClk) disable iff (!busRstN)
    hitEvt |=> flagQ);                                                // R7
  AST_CLEAR_BY_WRITE: assert property (@(posedge busClk) disable iff (!busRstN)
    $fell(flagQ) |-> $past(wrClrStb));                                // R7
  AST_CFG_LOCKED: assert property (@(posedge busClk) disable iff (!busRstN)
    cfg.run |=> $stable({cfg.srcSel, cfg.div512, cfg.div32}));        // R4
  AST_NO_RESERVED_SRC: assert property (@(posedge busClk) disable iff (!busRstN)
    cfg.srcSel != SRC_RESERVED);                                      // R3
  AST_FREEZE_STOPPED: assert property (@(posedge cntClk) disable iff (!cntRstN)
    !runLive |=> $stable(cntValue));                                  // R5
endmodule

bind rtc_api_timer rtc_api_checker uChk (
  .busClk  (busClk),
  .busRstN (busRstN),
  .cntClk  (cntClk),
  .cntRstN (cntRstN),
  .wrApiStb(wrEn && (addr == ADDR_W'(rtc_api_pkg::OFS_API))),
  .wrClrStb(wrEn && (addr == ADDR_W'(rtc_api_pkg::OFS_STAT)) && wrData[rtc_api_pkg::BIT_FLAG]),
  .busyQ   (busyQ),
  .flagQ   (flagQ),
  .hitEvt  (hitEvt),
  .cfg     (cfg),
  .apiHold (apiHold),
  .runLive (runLive),
  .cntValue(cntValue)
);

// File: tb/sim_rtc_api_timer.sv
module sim_rtc_api_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h04, A_STAT = 5'h08, A_API = 5'h10;

  logic busClk = 0, cntClk = 0, busRstN = 0, cntRstN = 0;
  logic wrEn = 0, rdEn = 0, src2 = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0, rdData, cntValue;
  logic        apiIrq;
  logic [3:0]  srcTick;
  int nChecks = 0, nFails = 0;
  logic [31:0] modelCtrl = '0;

  assign srcTick = {1'b0, src2, 1'b1, 1'b1};

  rtc_api_timer u0 (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .apiIrq(apiIrq), .cntClk(cntClk),
    .cntRstN(cntRstN), .srcTick(srcTick), .cntValue(cntValue)
  );

  initial forever #(CLK_PERIOD/2) busClk = ~busClk;
  initial begin #3; forever #(CLK_PERIOD/2) cntClk = ~cntClk; end
  initial forever begin @(negedge cntClk); src2 = ~src2; end

  function automatic logic [31:0] nextCtrl(input logic [31:0] cur, input logic [31:0] wd);
    logic [31:0] n = cur;
    n[31] = wd[31]; n[15] = wd[15]; n[14] = wd[14];
    if (!cur[31]) begin
      if (wd[13:12] != 2'd1) n[13:12] = wd[13:12];
      n[11] = wd[11]; n[10] = wd[10];
    end
    return n & 32'h8000_FC00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge busClk); wrEn = 1; addr = a; wrData = d;
    @(negedge busClk); wrEn = 0;
  endtask

  task automatic ctrlWrite(input logic [31:0] d);
    modelCtrl = nextCtrl(modelCtrl, d);
    busWrite(A_CTRL, d);
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge busClk); rdEn = 1; addr = a; #1; d = rdData; rdEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge busClk);
  endtask

  task automatic rateOver(input int cycles, output logic [31:0] delta);
    logic [31:0] c1;
    idle(10); c1 = cntValue; idle(cycles); delta = cntValue - c1;
  endtask

  task automatic waitIrq(input logic lvl, output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge busClk);
      if (apiIrq === lvl) begin ok = 1; return; end
    end
  endtask

  task automatic waitIdle(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      busRead(A_STAT, s);
      if (!s[17]) begin ok = 1; return; end
    end
  endtask

  task automatic clearFlag();
    logic [31:0] s;
    for (int i = 0; i < 4; i++) begin
      busWrite(A_STAT, 32'h0000_2000);
      busRead(A_STAT, s);
      if (!s[13]) return;
    end
  endtask

  task automatic firePeriod(output logic [31:0] delta);
    logic [31:0] c1;
    bit ok;
    clearFlag();
    waitIrq(1, ok); c1 = cntValue;
    busWrite(A_STAT, 32'h0000_2000);
    waitIrq(0, ok);
    waitIrq(1, ok);
    delta = ok ? cntValue - c1 : 32'hFFFF_FFFF;
  endtask

  initial begin
    repeat (180000) @(posedge busClk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d, s;
    bit ok;
    int seed;
    seed = $urandom(32'd2024);

    idle(5);
    busRstN = 1; cntRstN = 1;
    idle(2);
    // R1 reset state
    busRead(A_CTRL, d); chk("R1 ctrl", d, 0);
    busRead(A_STAT, d); chk("R1 status", d, 0);
    busRead(A_API, d);  chk("R1 interval", d, 0);
    chk("R1 irq", {31'd0, apiIrq}, 0);
    rateOver(40, d); chk("R1 count idle", cntValue | d, 0);
    // R11 other offsets and idle read
    busRead(5'h00, d); chk("R11 off0", d, 0);
    busRead(5'h14, d); chk("R11 off14", d, 0);
    chk("R11 rdEn low", rdData, 0);

    // R2 prescaler rates
    ctrlWrite(32'h8000_0000); rateOver(100, d);   chk("R2 undivided", d, 100);
    ctrlWrite(0); ctrlWrite(32'h8000_0400); rateOver(640, d);  chk("R2 div32", d, 20);
    ctrlWrite(0); ctrlWrite(32'h8000_0800); rateOver(3072, d); chk("R2 div512", d, 6);
    ctrlWrite(0); ctrlWrite(32'h8000_0C00); rateOver(32768, d); chk("R2 div16384", d, 2);

    // R3 source select and reserved index
    ctrlWrite(0); ctrlWrite(32'h8000_2000); rateOver(200, d); chk("R3 src2 half rate", d, 100);
    ctrlWrite(0); ctrlWrite(32'h8000_3000); rateOver(60, d);  chk("R3 src3 silent", d, 0);
    ctrlWrite(0); ctrlWrite(32'h8000_1000);
    busRead(A_CTRL, d); chk("R3 reserved keeps sel", d, 32'h8000_3000);

    // R4 config locked while running, enables always writable
    ctrlWrite(32'h8000_0C00); busRead(A_CTRL, d); chk("R4 locked cfg", d, 32'h8000_3000);
    ctrlWrite(32'h8000_C000); busRead(A_CTRL, d); chk("R4 enables", d, 32'h8000_F000);

    // R5 freeze while stopped
    ctrlWrite(0); ctrlWrite(32'h8000_0000); idle(20);
    ctrlWrite(0); rateOver(100, d); chk("R5 frozen", d, 0);

    // R9 busy handshake, R6 period, R7 sticky flag
    ctrlWrite(32'h8000_C000);
    busWrite(A_API, 40);
    busRead(A_STAT, s); chk("R9 busy set", {31'd0, s[17]}, 1);
    waitIdle(ok); chk("R9 busy clears", {31'd0, ok}, 1);
    busRead(A_API, d); chk("R9 readback", d, 40);
    firePeriod(d); chk("R6 period 40", d, 40);
    busRead(A_STAT, s); chk("R7 flag set", {31'd0, s[13]}, 1);
    busWrite(A_STAT, 32'h0000_0000);
    busRead(A_STAT, s); chk("R7 zero write no effect", {31'd0, s[13]}, 1);
    clearFlag(); busRead(A_STAT, s); chk("R7 cleared", {31'd0, s[13]}, 0);

    // R10 write while busy is dropped
    busWrite(A_API, 25); busWrite(A_API, 60);
    waitIdle(ok);
    busRead(A_API, d); chk("R10 second write dropped", d, 25);
    firePeriod(d); chk("R10 period stays 25", d, 25);

    // R6 random intervals
    for (int i = 0; i < 4; i++) begin
      logic [31:0] n;
      n = 16 + ($urandom % 64);
      busWrite(A_API, n); waitIdle(ok);
      firePeriod(d); chk("R6 random period", d, n);
    end

    // R8 interrupt gating
    busWrite(A_API, 30); waitIdle(ok);
    ctrlWrite(32'h8000_8000);
    clearFlag();
    s = 0;
    for (int i = 0; i < 200 && !s[13]; i++) busRead(A_STAT, s);
    chk("R8 flag without enable", {31'd0, s[13]}, 1);
    chk("R8 irq masked", {31'd0, apiIrq}, 0);
    ctrlWrite(32'h8000_C000);
    chk("R8 irq enabled", {31'd0, apiIrq}, 1);
    clearFlag(); #1; chk("R8 irq after clear", {31'd0, apiIrq}, 0);

    // R6 interval zero never fires
    busWrite(A_API, 0); waitIdle(ok); clearFlag();
    idle(300); busRead(A_STAT, s); chk("R6 zero never fires", {31'd0, s[13]}, 0);

    // R4 random control writes against model
    for (int i = 0; i < 16; i++) begin
      ctrlWrite($urandom);
      busRead(A_CTRL, d); chk("R4 random ctrl", d, modelCtrl);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule